// File: doc/BRIEF.md
# Four-Core Local Interrupt Router

This block sits beside a four-core processor cluster and decides which core hears which local interrupt, and on which of its two interrupt lines (a normal IRQ or a fast FIQ). Each core owns four timer lines, four mailbox-pending lines and a performance-monitor line. A single graphics-side interrupt is shared by the whole cluster. Software programs the routing through a 32-bit register interface. It can read back, per core, a pending word that shows which sources are both active and routed to that core.

The register interface has a write strobe, a byte address and write data. Read data is a combinational function of the address. Every core's IRQ and FIQ output is registered, so it follows the sources and the configuration one clock later. The timers, the mailbox storage and the bus fabric are outside the block; their lines arrive as plain level inputs.

Top module: `local_irq_router`

## Requirements
- R1: After a synchronous active-high reset, every configuration register reads zero and every IRQ and FIQ output is low.
- R2: The control word (0x00) and the prescaler word (0x08) are plain 32-bit read/write registers; 0x80000000 in the prescaler selects a 19.2 MHz timebase.
- R3: The timer config register of core n sits at 0x40+4n. Bit t enables the IRQ and bit t+4 enables the FIQ for that core's timer t. Bits 31:8 read zero.
- R4: The mailbox config register of core n sits at 0x50+4n. Bit m enables the IRQ and bit m+4 enables the FIQ for that core's mailbox m. Bits 31:8 read zero.
- R5: The shared graphics interrupt is routed by the word at 0x0C. It reaches the IRQ of exactly the core numbered in bits 1:0 and the FIQ of exactly the core numbered in bits 3:2, and no other core.
- R6: Writing ones to 0x10 sets performance-monitor enables, and writing ones to 0x14 clears them; zero bits leave enables unchanged. Bit c is the IRQ enable of core c and bit c+4 its FIQ enable. Both addresses read back the current enables.
- R7: The pending word of core n sits at 0x60+4n. Bits 3:0 are timers 0-3, bits 7:4 mailboxes 0-3, bit 8 the graphics interrupt and bit 9 the performance monitor. A bit reads 1 only while its source is active and routed to that core for IRQ or FIQ. Bits 31:10 read zero.
- R8: Pending words are read-only: writing them changes no register and no pending bit.
- R9: A core's IRQ output is, one clock later, the OR of its active sources enabled for IRQ. Its FIQ output is the same for sources enabled for FIQ.
- R10: Unmapped addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| tmr_i | input | 16 | Timer lines, core c timer t at bit 4c+t |
| mbox_i | input | 16 | Mailbox-pending lines, core c mailbox m at bit 4c+m |
| gpu_i | input | 1 | Shared graphics interrupt |
| pmu_i | input | 4 | Performance-monitor line per core |
| irq_o | output | 4 | IRQ per core |
| fiq_o | output | 4 | FIQ per core |

## Verification
The hardest case to reach is the graphics interrupt split across two different cores. It goes to the IRQ of one core and the FIQ of another, while the other two cores must stay silent. The stimulus programs distinct IRQ and FIQ core numbers and raises only the shared line. It then checks all four output pairs and all four pending words. The set/clear enable pair needs a history of overlapping writes before any enable state shows up at the outputs.

// File: rtl/lir_pkg.sv
package lir_pkg;
    localparam int unsigned N_TMR   = 4;
    localparam int unsigned N_MBOX  = 4;
    localparam int unsigned PEND_W  = N_TMR + N_MBOX + 2;

    // word indices (byte address >> 2)
    localparam int unsigned IDX_CTRL    = 0;
    localparam int unsigned IDX_PRESC   = 2;
    localparam int unsigned IDX_GPU     = 3;
    localparam int unsigned IDX_PMU_SET = 4;
    localparam int unsigned IDX_PMU_CLR = 5;
    localparam int unsigned IDX_TCFG    = 16;
    localparam int unsigned IDX_MCFG    = 20;
    localparam int unsigned IDX_PEND    = 24;

    typedef struct packed {
        logic [3:0] fiq;
        logic [3:0] irq;
    } en_pair_t;

    typedef struct packed {
        logic [1:0] fiq_core;
        logic [1:0] irq_core;
    } gpu_route_t;

    function automatic logic in_bank(int unsigned idx, int unsigned base, int unsigned n);
        return (idx >= base) && (idx < base + n);
    endfunction
endpackage

// File: rtl/lir_regs.sv
module lir_regs
    import lir_pkg::*;
#(
    parameter int unsigned NCORE = 4,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    addr,
    input  logic [DW-1:0]                    wdata,
    input  logic [NCORE-1:0][PEND_W-1:0]     pend,
    output logic [DW-1:0]                    rdata,
    output logic [DW-1:0]                    ctrl_q,
    output logic [DW-1:0]                    presc_q,
    output gpu_route_t                       gpu_q,
    output en_pair_t                         pmu_q,
    output en_pair_t [NCORE-1:0]             tcfg_q,
    output en_pair_t [NCORE-1:0]             mcfg_q
);
    localparam int unsigned IW = AW - 2;
    logic [IW-1:0] idx;
    int unsigned   widx;
    assign idx  = addr[AW-1:2];
    assign widx = int'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            gpu_q   <= '0;
            pmu_q   <= '0;
            tcfg_q  <= '0;
            mcfg_q  <= '0;
        end else if (wr_en) begin
            if (widx == IDX_CTRL)    ctrl_q  <= wdata;
            if (widx == IDX_PRESC)   presc_q <= wdata;
            if (widx == IDX_GPU)     gpu_q   <= gpu_route_t'(wdata[3:0]);
            if (widx == IDX_PMU_SET) pmu_q   <= pmu_q | en_pair_t'(wdata[7:0]);
            if (widx == IDX_PMU_CLR) pmu_q   <= pmu_q & ~en_pair_t'(wdata[7:0]);
            for (int c = 0; c < NCORE; c++) begin
                if (widx == IDX_TCFG + c) tcfg_q[c] <= en_pair_t'(wdata[7:0]);
                if (widx == IDX_MCFG + c) mcfg_q[c] <= en_pair_t'(wdata[7:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (widx == IDX_CTRL)  rdata = ctrl_q;
        if (widx == IDX_PRESC) rdata = presc_q;
        if (widx == IDX_GPU)   rdata = DW'(gpu_q);
        if (widx == IDX_PMU_SET || widx == IDX_PMU_CLR) rdata = DW'(pmu_q);
        for (int c = 0; c < NCORE; c++) begin
            if (widx == IDX_TCFG + c) rdata = DW'(tcfg_q[c]);
            if (widx == IDX_MCFG + c) rdata = DW'(mcfg_q[c]);
            if (widx == IDX_PEND + c) rdata = DW'(pend[c]);
        end
    end

    // R6: set address leaves the written ones set
    a_r6_pmu_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && widx == IDX_PMU_SET) |=>
            ((pmu_q & $past(wdata[7:0])) == $past(wdata[7:0])));

    // R6: clear address leaves the written ones cleared
    a_r6_pmu_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && widx == IDX_PMU_CLR) |=> ((pmu_q & $past(wdata[7:0])) == 8'h00));

    // R8: writes into the pending bank touch no configuration
    a_r8_pend_readonly: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_bank(widx, IDX_PEND, NCORE)) |=>
            ($stable(tcfg_q) && $stable(mcfg_q) && $stable(pmu_q) && $stable(gpu_q)
             && $stable(ctrl_q) && $stable(presc_q)));
endmodule

// File: rtl/lir_core_route.sv
module lir_core_route
    import lir_pkg::*;
#(
    parameter int unsigned CORE = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_TMR-1:0]    tmr,
    input  logic [N_MBOX-1:0]   mbox,
    input  logic                gpu,
    input  logic                pmu,
    input  en_pair_t            tcfg,
    input  en_pair_t            mcfg,
    input  gpu_route_t          gpu_route,
    input  en_pair_t            pmu_en,
    output logic [PEND_W-1:0]   pend,
    output logic                irq_q,
    output logic                fiq_q
);
    logic [PEND_W-1:0] src, irq_en, fiq_en;

    assign src    = {pmu, gpu, mbox, tmr};
    assign irq_en = {pmu_en.irq[CORE], gpu_route.irq_core == 2'(CORE), mcfg.irq, tcfg.irq};
    assign fiq_en = {pmu_en.fiq[CORE], gpu_route.fiq_core == 2'(CORE), mcfg.fiq, tcfg.fiq};
    assign pend   = src & (irq_en | fiq_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |(src & irq_en);
            fiq_q <= |(src & fiq_en);
        end
    end

    // R9: an output only follows a cycle with something pending
    a_r9_out_needs_pend: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> (!irq_q && !fiq_q));

    // R7: a pending bit never shows without its source
    a_r7_pend_has_src: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~src) == '0));
endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
    import lir_pkg::*;
#(
    parameter int unsigned NCORE = 4,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic [NCORE*N_TMR-1:0]  tmr_i,
    input  logic [NCORE*N_MBOX-1:0] mbox_i,
    input  logic                  gpu_i,
    input  logic [NCORE-1:0]      pmu_i,
    output logic [NCORE-1:0]      irq_o,
    output logic [NCORE-1:0]      fiq_o
);
    logic [DW-1:0]                ctrl_q, presc_q;
    gpu_route_t                   gpu_q;
    en_pair_t                     pmu_q;
    en_pair_t [NCORE-1:0]         tcfg_q, mcfg_q;
    logic [NCORE-1:0][PEND_W-1:0] pend;
    logic [NCORE-1:0]             gpu_pend;

    lir_regs #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pend(pend), .rdata(rdata), .ctrl_q(ctrl_q), .presc_q(presc_q),
        .gpu_q(gpu_q), .pmu_q(pmu_q), .tcfg_q(tcfg_q), .mcfg_q(mcfg_q)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        lir_core_route #(.CORE(c)) u_route (
            .clk(clk), .rst(rst),
            .tmr(tmr_i[c*N_TMR +: N_TMR]),
            .mbox(mbox_i[c*N_MBOX +: N_MBOX]),
            .gpu(gpu_i), .pmu(pmu_i[c]),
            .tcfg(tcfg_q[c]), .mcfg(mcfg_q[c]),
            .gpu_route(gpu_q), .pmu_en(pmu_q),
            .pend(pend[c]), .irq_q(irq_o[c]), .fiq_q(fiq_o[c])
        );
        assign gpu_pend[c] = pend[c][N_TMR+N_MBOX];
    end

    // R5: with one shared target core the graphics line reaches at most one core
    a_r5_gpu_single: assert property (@(posedge clk) disable iff (rst)
        (gpu_q.irq_core == gpu_q.fiq_core) |-> $onehot0(gpu_pend));

    // R5: never more than the two selected cores
    a_r5_gpu_two_max: assert property (@(posedge clk) disable iff (rst)
        ($countones(gpu_pend) <= 2));

    // R1: outputs quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0 && fiq_o == '0));
endmodule

// File: tb/local_irq_router_bench.sv
module local_irq_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] tmr_i = '0;
    logic [15:0] mbox_i = '0;
    logic        gpu_i = 1'b0;
    logic [3:0]  pmu_i = '0;
    logic [3:0]  irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    local_irq_router u_local_irq_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tmr_i(tmr_i), .mbox_i(mbox_i), .gpu_i(gpu_i),
        .pmu_i(pmu_i), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [7:0] cfg_addrs[9] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h40, 8'h4C, 8'h50, 8'h5C};
        foreach (cfg_addrs[i]) begin
            rd(cfg_addrs[i], v);
            chk("R1 config zero", v, 0);
        end
        chk("R1 irq low", {28'd0, irq_o}, 0);
        chk("R1 fiq low", {28'd0, fiq_o}, 0);
    endtask

    task automatic t_plain();
        logic [31:0] v;
        wr(8'h00, 32'hA5A5_0001);
        wr(8'h08, 32'h8000_0000);
        rd(8'h00, v); chk("R2 control", v, 32'hA5A5_0001);
        rd(8'h08, v); chk("R2 prescaler", v, 32'h8000_0000);
    endtask

    task automatic t_timer();
        logic [31:0] v;
        wr(8'h44, 32'hFFFF_FF01);
        rd(8'h44, v); chk("R3 upper bits zero", v, 32'h01);
        tmr_i[4] = 1'b1;               // core 1 timer 0
        settle();
        chk("R9 timer irq core1", {28'd0, irq_o}, 32'h2);
        chk("R9 timer no fiq", {28'd0, fiq_o}, 32'h0);
        rd(8'h64, v); chk("R7 pend core1 timer0", v, 32'h001);
        rd(8'h60, v); chk("R7 pend core0 empty", v, 32'h0);
        tmr_i = '0;
        wr(8'h44, 32'h20);             // timer1 FIQ
        tmr_i[5] = 1'b1;
        settle();
        chk("R3 timer fiq core1", {28'd0, fiq_o}, 32'h2);
        chk("R3 timer fiq no irq", {28'd0, irq_o}, 32'h0);
        tmr_i = '0;
        settle();
        chk("R9 timer drop", {28'd0, fiq_o}, 32'h0);
    endtask

    task automatic t_mbox();
        logic [31:0] v;
        wr(8'h58, 32'h08);             // core2 mailbox3 IRQ
        mbox_i[11] = 1'b1;
        mbox_i[8]  = 1'b1;             // mailbox0 not enabled
        settle();
        rd(8'h68, v); chk("R4 pend core2 mbox3 only", v, 32'h080);
        chk("R4 mbox irq core2", {28'd0, irq_o}, 32'h4);
        mbox_i = '0;
        settle();
        chk("R4 mbox drop", {28'd0, irq_o}, 32'h0);
    endtask

    task automatic t_gpu();
        logic [31:0] v;
        wr(8'h0C, 32'hD);              // IRQ core1, FIQ core3
        rd(8'h0C, v); chk("R5 route readback", v, 32'hD);
        gpu_i = 1'b1;
        settle();
        chk("R5 gpu irq core1 only", {28'd0, irq_o}, 32'h2);
        chk("R5 gpu fiq core3 only", {28'd0, fiq_o}, 32'h8);
        rd(8'h64, v); chk("R5 pend core1", v, 32'h100);
        rd(8'h6C, v); chk("R5 pend core3", v, 32'h100);
        rd(8'h60, v); chk("R5 pend core0", v, 32'h0);
        rd(8'h68, v); chk("R5 pend core2", v, 32'h0);
        gpu_i = 1'b0;
        wr(8'h0C, 32'hF);              // both to core3, keeps core0 quiet later
    endtask

    task automatic t_pmu();
        logic [31:0] v;
        wr(8'h10, 32'h11);
        rd(8'h10, v); chk("R6 set read", v, 32'h11);
        wr(8'h10, 32'h80);
        rd(8'h14, v); chk("R6 set merges", v, 32'h91);
        wr(8'h14, 32'h01);
        rd(8'h10, v); chk("R6 clear", v, 32'h90);
        pmu_i = 4'hF;
        settle();
        chk("R6 pmu fiq cores 0,3", {28'd0, fiq_o}, 32'h9);
        chk("R6 pmu no irq", {28'd0, irq_o}, 32'h0);
        rd(8'h60, v); chk("R7 pend core0 pmu", v, 32'h200);
        rd(8'h64, v); chk("R7 pend core1 pmu off", v, 32'h0);
        pmu_i = '0;
    endtask

    task automatic t_pend_ro();
        logic [31:0] v;
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h60, v); chk("R8 pend unchanged", v, 32'h0);
        rd(8'h44, v); chk("R8 tcfg intact", v, 32'h20);
        rd(8'h10, v); chk("R8 pmu intact", v, 32'h90);
        // everything on for core 0: upper bits stay zero
        wr(8'h40, 32'hFF);
        wr(8'h50, 32'hFF);
        wr(8'h0C, 32'h0);
        wr(8'h10, 32'hFF);
        tmr_i = '1; mbox_i = '1; gpu_i = 1'b1; pmu_i = '1;
        settle();
        rd(8'h60, v); chk("R7 pend full width", v, 32'h3FF);
        tmr_i = '0; mbox_i = '0; gpu_i = 1'b0; pmu_i = '0;
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h70, 32'hDEAD_BEEF);
        rd(8'h04, v); chk("R10 unmapped 0x04", v, 32'h0);
        rd(8'h18, v); chk("R10 unmapped 0x18", v, 32'h0);
        rd(8'h70, v); chk("R10 unmapped 0x70", v, 32'h0);
        rd(8'h00, v); chk("R10 control intact", v, 32'hA5A5_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_timer();
        t_mbox();
        t_gpu();
        t_pmu();
        t_pend_ro();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule